// File: doc/BRIEF.md
# Page Buffer Load Sequencer

This block holds a 256-byte staging buffer in front of a behavioural non-volatile array. It watches the bus write strobe and decodes the multi-cycle commands that open and close a load window, stream 256 data bytes into the buffer, and copy the buffer into one page of the array. A load window opens with a three-cycle command, the opcode followed by two dummy cycles, and closes with another three-cycle command. Inside an open window a three-byte sequential-load command arms a data phase. That phase takes exactly 256 writes, and each write selects its buffer slot from the low address byte only.

A two-cycle program command copies the buffer into the page named by the confirm cycle's upper address bits, one byte per clock. Bits can only fall from 1 to 0. A sticky flag reports any cell that could not reach its target value. Each buffer byte returns to FFh once it has been copied. While the command interpreter's suspend signal is high, the copy stalls, and when suspend rises the whole buffer is invalidated to FFh.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, busy is 0, over_prog is 0, load_cnt is 0, every array byte reads FFh and every buffer byte holds FFh.
- R2: Writing DBh and then any two dummy bytes opens the load window. Inside the window, E0h, FFh, 00h sets load_cnt to 0 and starts the data phase. Each data write stores its data at buffer slot wr_addr[7:0], ignores the upper address bits and increments load_cnt.
- R3: A dummy pair equal to 20h then D0h, or 77h then D0h, rejects the command. A rejected DBh leaves the window closed, and a rejected 5Fh leaves it open.
- R4: The data phase ends after 256 writes, and load_cnt then holds 256. A later write that is not a command leaves the buffer unchanged.
- R5: The sequential-load command needs FFh exactly as its second byte and 00h exactly as its third. Any other byte abandons the command with no effect on load_cnt.
- R6: Writing 0Eh and then D0h starts a copy into page wr_addr[ADDR_W-1:8] of the confirm cycle, ignoring its low byte. busy is high for exactly 256 cycles with no suspend, and each array byte becomes old AND buffer.
- R7: After a copy, every buffer byte is FFh, so programming another page without a new load leaves that page unchanged.
- R8: over_prog goes to 1 when a buffer byte has a 1 where the array byte holds 0. It is cleared when the next copy starts.
- R9: While susp is high the copy stalls, so busy lasts one extra cycle per stalled cycle. A rising edge of susp sets every buffer byte to FFh.
- R10: All writes are ignored while busy is high.
- R11: Writing 5Fh and then two dummy bytes that are not a rejected pair closes the window. A sequential-load command is then ignored.
- R12: 0Eh followed by any byte other than D0h is abandoned, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address (low byte = buffer slot, upper bits = page) |
| wr_data | input | 8 | Write data / command byte |
| susp | input | 1 | Suspend level from command interpreter |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| busy | output | 1 | Copy into the array in progress |
| over_prog | output | 1 | Sticky flag: a cell could not reach its target |
| load_cnt | output | 9 | Data writes taken in the current sequential load |

## Verification
A decoder state that has slipped by one cycle shows up on load_cnt at the very next write: it fails to clear to 0 on a sequential-load command or fails to step on a data write. A buffer that is wrongly kept, cleared or written stays hidden until the next copy. It then appears in array bytes read back 256 cycles later, so the bench programs fresh pages and reads specific bytes. Stall and engine errors appear as a busy window longer or shorter than the exact cycle count.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 8;
    localparam int PAGE_BYTES = 1 << IDX_W;
    localparam int CNT_W      = IDX_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_OPEN   = 8'hDB;
    localparam byte_t OP_CLOSE  = 8'h5F;
    localparam byte_t OP_SEQ    = 8'hE0;
    localparam byte_t SEQ_KEY1  = 8'hFF;
    localparam byte_t SEQ_KEY2  = 8'h00;
    localparam byte_t OP_PROG   = 8'h0E;
    localparam byte_t OP_CONF   = 8'hD0;
    localparam byte_t BAD_ERASE = 8'h20;
    localparam byte_t BAD_LOCK  = 8'h77;
    localparam byte_t ERASED    = 8'hFF;

    typedef enum logic [3:0] {
        S_CMD, S_OPEN1, S_OPEN2, S_CLOSE1, S_CLOSE2,
        S_SEQ1, S_SEQ2, S_DATA, S_PCONF
    } seq_state_e;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        byte_t            data;
    } buf_wr_t;

    function automatic logic dummy_rejected(byte_t first, byte_t second);
        return (second == OP_CONF) && ((first == BAD_ERASE) || (first == BAD_LOCK));
    endfunction
endpackage

// File: rtl/pgbuf_cmd_seq.sv
module pgbuf_cmd_seq
    import pgbuf_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int ADDR_W = IDX_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    input  logic              busy,
    output buf_wr_t           ld,
    output logic [CNT_W-1:0]  load_cnt,
    output logic              prog_go,
    output logic [PAGE_W-1:0] prog_page
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PAGE_BYTES);

    seq_state_e st;
    logic       win_open;
    byte_t      dummy1;
    logic       take;

    assign take = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_CMD;
            win_open <= 1'b0;
            dummy1   <= '0;
            load_cnt <= '0;
        end else if (take) begin
            case (st)
                S_CMD: begin
                    if (wr_data == OP_OPEN)                   st <= S_OPEN1;
                    else if (wr_data == OP_CLOSE)             st <= S_CLOSE1;
                    else if (wr_data == OP_SEQ && win_open)   st <= S_SEQ1;
                    else if (wr_data == OP_PROG)              st <= S_PCONF;
                end
                S_OPEN1, S_CLOSE1: begin
                    dummy1 <= wr_data;
                    st     <= (st == S_OPEN1) ? S_OPEN2 : S_CLOSE2;
                end
                S_OPEN2: begin
                    st <= S_CMD;
                    if (!dummy_rejected(dummy1, wr_data)) win_open <= 1'b1;
                end
                S_CLOSE2: begin
                    st <= S_CMD;
                    if (!dummy_rejected(dummy1, wr_data)) win_open <= 1'b0;
                end
                S_SEQ1: st <= (wr_data == SEQ_KEY1) ? S_SEQ2 : S_CMD;
                S_SEQ2: begin
                    if (wr_data == SEQ_KEY2) begin
                        st       <= S_DATA;
                        load_cnt <= '0;
                    end else begin
                        st <= S_CMD;
                    end
                end
                S_DATA: begin
                    load_cnt <= load_cnt + 1'b1;
                    if (load_cnt == LAST_IDX) st <= S_CMD;
                end
                S_PCONF: st <= S_CMD;
                default: st <= S_CMD;
            endcase
        end
    end

    always_comb begin
        ld.we     = take && (st == S_DATA);
        ld.idx    = wr_addr[IDX_W-1:0];
        ld.data   = wr_data;
        prog_go   = take && (st == S_PCONF) && (wr_data == OP_CONF);
        prog_page = wr_addr[ADDR_W-1:IDX_W];
    end

    // R4: the counter never passes a full page
    a_r4_cnt_cap: assert property (@(posedge clk) disable iff (rst)
        load_cnt <= FULL_CNT);
    // R4: a full count stays put unless a new sequential load is armed
    a_r4_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (load_cnt == FULL_CNT && st != S_SEQ2) |=> load_cnt == FULL_CNT);
    // R11: the data phase is only reachable with an open window
    a_r11_data_needs_window: assert property (@(posedge clk) disable iff (rst)
        (st == S_DATA) |-> win_open);
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store
    import pgbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  buf_wr_t          ld,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             clr_one,
    input  logic             clr_all,
    input  logic             busy,
    output byte_t            rd_byte
);
    byte_t mem [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            for (int i = 0; i < PAGE_BYTES; i++) mem[i] <= ERASED;
        end else begin
            if (clr_one)  mem[rd_idx] <= ERASED;
            if (ld.we)    mem[ld.idx] <= ld.data;
        end
    end

    assign rd_byte = mem[rd_idx];

    // R10: no load reaches the buffer while a copy is running
    a_r10_no_load_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ld.we);
    // R7: a byte the engine has consumed reads erased next cycle
    a_r7_consumed_erased: assert property (@(posedge clk) disable iff (rst)
        clr_one |=> mem[$past(rd_idx)] == ERASED);
endmodule

// File: rtl/pgbuf_engine.sv
module pgbuf_engine
    import pgbuf_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [PAGE_W-1:0] go_page,
    input  logic              susp,
    input  byte_t             buf_byte,
    input  byte_t             arr_byte,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic [PAGE_W-1:0] page_q,
    output logic              arr_we,
    output byte_t             arr_wdata,
    output logic              clr_one,
    output logic              susp_rise,
    output logic              over_prog
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAGE_BYTES - 1);

    logic susp_q;
    logic step;

    assign step      = busy && !susp;
    assign susp_rise = susp && !susp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            idx       <= '0;
            page_q    <= '0;
            over_prog <= 1'b0;
            susp_q    <= 1'b0;
        end else begin
            susp_q <= susp;
            if (go) begin
                busy      <= 1'b1;
                idx       <= '0;
                page_q    <= go_page;
                over_prog <= 1'b0;
            end else if (step) begin
                idx <= idx + 1'b1;
                if (idx == LAST) busy <= 1'b0;
                if ((arr_byte & buf_byte) != buf_byte) over_prog <= 1'b1;
            end
        end
    end

    always_comb begin
        arr_we    = step;
        arr_wdata = arr_byte & buf_byte;
        clr_one   = step;
    end

    // R9: a suspended copy does not advance
    a_r9_stall: assert property (@(posedge clk) disable iff (rst)
        (busy && susp) |=> $stable(idx) && busy);
    // R8: a fresh copy starts with a clean flag
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !over_prog);
    // R6: a confirm is only issued when idle
    a_r6_go_idle: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);
endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array
    import pgbuf_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int AW     = IDX_W + PAGE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] eng_addr,
    input  byte_t         wdata,
    input  logic [AW-1:0] rd_addr,
    output byte_t         eng_rdata,
    output byte_t         rd_data
);
    localparam int DEPTH = 1 << AW;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (we) begin
            mem[eng_addr] <= wdata;
        end
    end

    assign eng_rdata = mem[eng_addr];
    assign rd_data   = mem[rd_addr];

    // R6: a cell never rises from 0 to 1
    a_r6_bits_fall: assert property (@(posedge clk) disable iff (rst)
        we |-> (wdata & ~eng_rdata) == '0);
endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top
    import pgbuf_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int ADDR_W = IDX_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              susp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              over_prog,
    output logic [8:0]        load_cnt
);
    buf_wr_t           ld;
    logic              prog_go;
    logic [PAGE_W-1:0] prog_page;
    logic [PAGE_W-1:0] page_q;
    logic [IDX_W-1:0]  idx;
    byte_t             buf_byte, arr_byte, arr_wdata;
    logic              arr_we, clr_one, susp_rise;

    pgbuf_cmd_seq #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .ld(ld), .load_cnt(load_cnt),
        .prog_go(prog_go), .prog_page(prog_page)
    );

    pgbuf_store u_buf (
        .clk(clk), .rst(rst), .ld(ld), .rd_idx(idx), .clr_one(clr_one),
        .clr_all(susp_rise), .busy(busy), .rd_byte(buf_byte)
    );

    pgbuf_engine #(.PAGE_W(PAGE_W)) u_eng (
        .clk(clk), .rst(rst), .go(prog_go), .go_page(prog_page),
        .susp(susp), .buf_byte(buf_byte), .arr_byte(arr_byte),
        .busy(busy), .idx(idx), .page_q(page_q), .arr_we(arr_we),
        .arr_wdata(arr_wdata), .clr_one(clr_one), .susp_rise(susp_rise),
        .over_prog(over_prog)
    );

    pgbuf_array #(.PAGE_W(PAGE_W), .AW(ADDR_W)) u_arr (
        .clk(clk), .rst(rst), .we(arr_we), .eng_addr({page_q, idx}),
        .wdata(arr_wdata), .rd_addr(rd_addr), .eng_rdata(arr_byte),
        .rd_data(rd_data)
    );
endmodule

// File: tb/pgbuf_top_tb.sv
module pgbuf_top_tb;
    localparam int AW = 11;
    localparam int NVEC = 9;
    // each entry: {address, data, expected load_cnt after the write}
    localparam logic [27:0] VEC [NVEC] = '{
        {11'h000, 8'hDB, 9'd0}, {11'h000, 8'h00, 9'd0}, {11'h000, 8'h00, 9'd0},
        {11'h000, 8'hE0, 9'd0}, {11'h000, 8'hFF, 9'd0}, {11'h000, 8'h00, 9'd0},
        {11'h703, 8'h12, 9'd1}, {11'h510, 8'hA5, 9'd2}, {11'h001, 8'h3C, 9'd3}
    };

    logic          clk = 0, rst = 1, wr_en = 0, susp = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_data = '0, rd_data;
    logic          busy, over_prog;
    logic [8:0]    load_cnt;
    int            checks = 0, failures = 0, busy_cycles = 0;
    bit            done = 0;

    pgbuf_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .susp(susp), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .over_prog(over_prog),
        .load_cnt(load_cnt)
    );

    always #2 clk = ~clk;
    always @(negedge clk) if (busy) busy_cycles++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #0.1;
        chk(req, int'(rd_data), int'(exp));
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
    endtask

    task automatic seq_fill(input int ia, input logic [7:0] va,
                            input int ib, input logic [7:0] vb);
        for (int i = 0; i < 256; i++)
            wr(AW'(i), (i == ia) ? va : (i == ib) ? vb : 8'hFF);
    endtask

    task automatic program_page(input logic [AW-1:0] a, output int n);
        int b0;
        b0 = busy_cycles;
        wr(11'h000, 8'h0E);
        wr(a, 8'hD0);
        wait_idle();
        n = busy_cycles - b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 load_cnt", load_cnt, 0);
        chk("R1 over_prog", over_prog, 0);
        rd_chk("R1 array erased", 11'h7FF, 8'hFF);

        // R2 table walk: open, arm, three data writes with junk upper bits
        for (int v = 0; v < NVEC; v++) begin
            wr(VEC[v][27:17], VEC[v][16:9]);
            chk($sformatf("R2 vec%0d load_cnt", v), load_cnt, int'(VEC[v][8:0]));
        end
        for (int i = 3; i < 256; i++) wr(11'h0FF, 8'hFF);
        chk("R4 count full", load_cnt, 256);
        wr(11'h010, 8'h00);
        chk("R4 count saturated", load_cnt, 256);
        wr(11'h000, 8'h5F); wr(11'h000, 8'h00); wr(11'h000, 8'h00);

        // R6 program page 2, low byte of confirm address ignored
        program_page(11'h277, n);
        chk("R6 busy cycles", n, 256);
        rd_chk("R6 byte03", 11'h203, 8'h12);
        rd_chk("R4 byte10 kept", 11'h210, 8'hA5);
        rd_chk("R6 byte01", 11'h201, 8'h3C);
        rd_chk("R6 byte00", 11'h200, 8'hFF);
        rd_chk("R6 other page", 11'h303, 8'hFF);
        chk("R6 no over_prog", over_prog, 0);

        // R7 buffer empty after copy
        program_page(11'h000, n);
        rd_chk("R7 page0 byte03", 11'h003, 8'hFF);

        // R8 over-program: A5 AND F0
        wr(0, 8'hDB); wr(0, 8'h00); wr(0, 8'h00);
        wr(0, 8'hE0); wr(0, 8'hFF); wr(0, 8'h00);
        seq_fill(16, 8'hF0, -1, 8'hFF);
        wr(0, 8'h5F); wr(0, 8'h00); wr(0, 8'h00);
        program_page(11'h200, n);
        chk("R8 flag set", over_prog, 1);
        rd_chk("R8 byte10 anded", 11'h210, 8'hA0);
        program_page(11'h400, n);
        chk("R8 flag cleared", over_prog, 0);

        // R3 rejected open, window closed, count unchanged
        wr(0, 8'hDB); wr(0, 8'h20); wr(0, 8'hD0);
        wr(0, 8'hE0); wr(0, 8'hFF); wr(0, 8'h00);
        chk("R3 open rejected erase pair", load_cnt, 256);
        wr(0, 8'hDB); wr(0, 8'h77); wr(0, 8'hD0);
        wr(0, 8'hE0); wr(0, 8'hFF); wr(0, 8'h00);
        chk("R3 open rejected lock pair", load_cnt, 256);

        // R11 close then sequential load ignored
        wr(0, 8'hDB); wr(0, 8'h01); wr(0, 8'h02);
        wr(0, 8'h5F); wr(0, 8'h03); wr(0, 8'h04);
        wr(0, 8'hE0); wr(0, 8'hFF); wr(0, 8'h00);
        chk("R11 closed window", load_cnt, 256);

        // R3 rejected close keeps window open
        wr(0, 8'hDB); wr(0, 8'h00); wr(0, 8'h00);
        wr(0, 8'hE0); wr(0, 8'hFF); wr(0, 8'h00);
        chk("R2 seq clears count", load_cnt, 0);
        seq_fill(-1, 8'hFF, -1, 8'hFF);
        wr(0, 8'h5F); wr(0, 8'h77); wr(0, 8'hD0);
        wr(0, 8'hE0); wr(0, 8'hFF); wr(0, 8'h00);
        chk("R3 close rejected", load_cnt, 0);
        seq_fill(-1, 8'hFF, -1, 8'hFF);
        wr(0, 8'h5F); wr(0, 8'h00); wr(0, 8'h00);

        // R5 malformed sequential load
        wr(0, 8'hDB); wr(0, 8'h00); wr(0, 8'h00);
        wr(0, 8'hE0); wr(0, 8'hFE); wr(0, 8'h00);
        chk("R5 bad key ignored", load_cnt, 256);
        wr(0, 8'hE0); wr(0, 8'hFF); wr(0, 8'h00);
        chk("R5 good key", load_cnt, 0);
        seq_fill(1, 8'h00, 200, 8'h00);

        // R9 and R10 during a copy to page 5
        wr(0, 8'h0E);
        n = busy_cycles;
        wr(11'h5AB, 8'hD0);
        wr(0, 8'hE0); wr(0, 8'hFF); wr(0, 8'h00);
        chk("R10 writes ignored while busy", load_cnt, 256);
        susp = 1;
        repeat (20) @(negedge clk);
        chk("R9 busy held in suspend", busy, 1);
        susp = 0;
        wait_idle();
        chk("R9 stalled busy cycles", busy_cycles - n, 276);
        rd_chk("R9 copied before suspend", 11'h501, 8'h00);
        rd_chk("R9 buffer dropped", 11'h5C8, 8'hFF);

        // R12 bad confirm
        wr(0, 8'h0E); wr(11'h600, 8'h55);
        chk("R12 no start", busy, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule